// File: doc/BRIEF.md
# Generation-Bit Descriptor Ring Consumer

This block takes egress work items from a circular ring kept in local storage. Software fills the ring through a plain write port. The consumer reads it back through a port with one cycle of read latency. Software and hardware never exchange head or tail pointers. Each entry instead carries a generation bit. The consumer holds an expected generation value and inverts it each time its read index wraps from the last slot back to slot zero. An entry whose bit does not match is still an entry from the previous lap, and the consumer waits on that slot until software rewrites it.

Each valid entry becomes one transfer command to a downstream data mover. The command holds the byte count, the end-of-packet flag, the discard flag, the notify flag, the egress queue choice and a buffer handle. A discard entry or an entry with zero length still produces a command, so its buffers can be handed back. The data mover reports each finished command on a completion strobe, in issue order. When the finished command closed a packet and asked for a notification, the block raises a one-cycle interrupt pulse. The number of commands in flight is bounded, so the notify flag of every issued command is kept until its completion arrives.

Top module: `desc_ring_consumer`

## Requirements
- R1: A ring entry is 32 bits wide. Bit 31 is the generation bit, bits 30:25 the queue select, bit 24 the discard flag, bit 23 the notify flag, bit 22 the end-of-packet flag, bits 21:8 the byte count and bits 7:0 the buffer handle. A write with `wr_en` high stores `wr_data` into slot `wr_slot` at the clock edge, in any cycle.
- R2: After synchronous reset, the read index is 0, the expected generation is 1, every slot holds 0, `cmd_valid` is low and `notify_irq` is low.
- R3: An entry whose generation bit differs from the expected value is never issued. The consumer stays on that slot and polls it again until a matching entry is written there.
- R4: Slots are consumed in order 0, 1, …, DEPTH-1, 0, …. The expected generation inverts each time the index wraps to 0, so lap k expects generation 1 when k is even and 0 when k is odd.
- R5: `cmd_bytes` equals the byte count, except that it is 0 when the discard flag is set. `cmd_last`, `cmd_discard` and `cmd_notify` copy the entry's flags.
- R6: `cmd_handle` equals the buffer handle, except that it is 0 when the entry's byte count field is 0.
- R7: `cmd_fifo` is the entry's queue select when `allow_sel` is 1, and `default_fifo` otherwise.
- R8: A command is transferred when `cmd_valid` and `cmd_ready` are both high at a clock edge. While `cmd_ready` is low, `cmd_valid` stays high with unchanged contents and the index does not move.
- R9: At most MAX_OUTST commands are issued and not yet completed. `cmd_valid` is low while that many are outstanding.
- R10: `notify_irq` is high for exactly the one cycle after a `done_valid` edge that completes the oldest outstanding command, and only if that command had both the end-of-packet and notify flags set.
- R11: A `done_valid` while nothing is outstanding is ignored. It produces no pulse and has no effect on later completions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Software ring write strobe |
| wr_slot | input | $clog2(RING_DEPTH) | Slot to write |
| wr_data | input | 32 | Entry word to store |
| allow_sel | input | 1 | Lets the entry choose its egress queue |
| default_fifo | input | 6 | Queue used when selection is not allowed |
| cmd_valid | output | 1 | Transfer command available |
| cmd_ready | input | 1 | Data mover accepts the command |
| cmd_bytes | output | 14 | Bytes to move |
| cmd_last | output | 1 | Command ends a packet |
| cmd_discard | output | 1 | Command moves no data, only returns buffers |
| cmd_notify | output | 1 | Entry requested notification |
| cmd_fifo | output | 6 | Egress queue |
| cmd_handle | output | 8 | Buffer handle |
| done_valid | input | 1 | Data mover finished the oldest command |
| notify_irq | output | 1 | One-cycle notification pulse |

## Verification
Two events can land in the same cycle. A new command can be accepted on the same edge where `done_valid` retires an older one, and software can rewrite the slot the consumer is polling while the read of that slot is in flight. Random `cmd_ready` and `done_valid` patterns, together with a producer that refills each slot as soon as it is freed, create both overlaps many times. The bench judges them by comparing every issued command against its own list of written entries, and every cycle of `notify_irq` against a completion queue it keeps itself. Directed phases hold back stale entries, rewrite a polled slot first with the wrong generation, stall on `cmd_ready` and pulse `done_valid` with nothing outstanding.

// File: rtl/dring_pkg.sv
package dring_pkg;

    localparam int ENTRY_W  = 32;
    localparam int BYTES_W  = 14;
    localparam int SEL_W    = 6;
    localparam int HANDLE_W = 8;

    typedef struct packed {
        logic                gen;
        logic [SEL_W-1:0]    fifo_sel;
        logic                discard;
        logic                notify;
        logic                last;
        logic [BYTES_W-1:0]  bytes;
        logic [HANDLE_W-1:0] handle;
    } ring_entry_t;

    typedef struct packed {
        logic [BYTES_W-1:0]  bytes;
        logic                last;
        logic                discard;
        logic                notify;
        logic [SEL_W-1:0]    fifo;
        logic [HANDLE_W-1:0] handle;
    } xfer_cmd_t;

    typedef enum logic [1:0] {
        ST_FETCH = 2'd0,
        ST_CHECK = 2'd1,
        ST_ISSUE = 2'd2
    } fetch_st_e;

    function automatic xfer_cmd_t build_cmd(input ring_entry_t e,
                                            input logic allow,
                                            input logic [SEL_W-1:0] dflt);
        xfer_cmd_t c;
        c.bytes   = e.discard ? '0 : e.bytes;
        c.last    = e.last;
        c.discard = e.discard;
        c.notify  = e.notify;
        c.fifo    = allow ? e.fifo_sel : dflt;
        c.handle  = (e.bytes == '0) ? '0 : e.handle;
        return c;
    endfunction

    function automatic logic wants_irq(input ring_entry_t e);
        return e.last & e.notify;
    endfunction

endpackage

// File: rtl/dring_mem.sv
module dring_mem
    import dring_pkg::*;
#(
    parameter int DEPTH  = 8,
    localparam int SLOT_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [SLOT_W-1:0] wr_slot,
    input  ring_entry_t       wr_entry,
    input  logic [SLOT_W-1:0] rd_addr,
    output ring_entry_t       rd_entry
);

    ring_entry_t slots [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) begin
                slots[i] <= '0;
            end
        end else if (wr_en) begin
            slots[wr_slot] <= wr_entry;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_entry <= '0;
        end else begin
            rd_entry <= slots[rd_addr];
        end
    end

endmodule

// File: rtl/dring_fetch.sv
module dring_fetch
    import dring_pkg::*;
#(
    parameter int DEPTH  = 8,
    localparam int SLOT_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    output logic [SLOT_W-1:0] rd_addr,
    input  ring_entry_t       rd_entry,
    input  logic              allow_sel,
    input  logic [SEL_W-1:0]  default_fifo,
    input  logic              stall_full,
    output logic              cmd_valid,
    input  logic              cmd_ready,
    output xfer_cmd_t         cmd,
    output logic              fire,
    output logic              fire_irq
);

    localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(DEPTH - 1);

    fetch_st_e         state;
    logic [SLOT_W-1:0] idx;
    logic              exp_gen;
    ring_entry_t       held;
    logic              match;

    assign match     = (rd_entry.gen == exp_gen);
    assign rd_addr   = idx;
    assign cmd_valid = (state == ST_ISSUE) && !stall_full;
    assign fire      = cmd_valid && cmd_ready;
    assign cmd       = build_cmd(held, allow_sel, default_fifo);
    assign fire_irq  = wants_irq(held);

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_FETCH;
            idx     <= '0;
            exp_gen <= 1'b1;
            held    <= '0;
        end else begin
            unique case (state)
                ST_FETCH: state <= ST_CHECK;
                ST_CHECK: begin
                    if (match) begin
                        held  <= rd_entry;
                        state <= ST_ISSUE;
                    end else begin
                        state <= ST_FETCH;
                    end
                end
                ST_ISSUE: begin
                    if (fire) begin
                        state <= ST_FETCH;
                        if (idx == LAST_SLOT) begin
                            idx     <= '0;
                            exp_gen <= ~exp_gen;
                        end else begin
                            idx <= idx + 1'b1;
                        end
                    end
                end
                default: state <= ST_FETCH;
            endcase
        end
    end

    // R3: a mismatching entry sends the consumer back to poll the same slot
    a_r3_stale_repoll: assert property (@(posedge clk) disable iff (rst)
        (state == ST_CHECK && !match) |=> (state == ST_FETCH && $stable(idx)));

    // R4: wrap returns to slot 0 and inverts the expected generation
    a_r4_wrap_flip: assert property (@(posedge clk) disable iff (rst)
        (fire && idx == LAST_SLOT) |=> (idx == '0 && exp_gen != $past(exp_gen)));

    // R8: an offered command holds until taken
    a_r8_hold: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd) && $stable(idx)));

endmodule

// File: rtl/dring_track.sv
module dring_track #(
    parameter int MAX_OUTST = 4,
    localparam int PTR_W = (MAX_OUTST > 1) ? $clog2(MAX_OUTST) : 1,
    localparam int CNT_W = $clog2(MAX_OUTST + 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic push,
    input  logic push_irq,
    input  logic done_valid,
    output logic full,
    output logic notify_irq
);

    localparam logic [CNT_W-1:0] CNT_MAX  = CNT_W'(MAX_OUTST);
    localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(MAX_OUTST - 1);

    logic [MAX_OUTST-1:0] flags;
    logic [PTR_W-1:0]     wr_ptr;
    logic [PTR_W-1:0]     rd_ptr;
    logic [CNT_W-1:0]     count;
    logic                 pop;

    assign full = (count == CNT_MAX);
    assign pop  = done_valid && (count != '0);

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_LAST) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            flags      <= '0;
            wr_ptr     <= '0;
            rd_ptr     <= '0;
            count      <= '0;
            notify_irq <= 1'b0;
        end else begin
            notify_irq <= pop && flags[rd_ptr];
            if (push) begin
                flags[wr_ptr] <= push_irq;
                wr_ptr        <= bump(wr_ptr);
            end
            if (pop) begin
                rd_ptr <= bump(rd_ptr);
            end
            if (push && !pop) begin
                count <= count + 1'b1;
            end else if (pop && !push) begin
                count <= count - 1'b1;
            end
        end
    end

    // R9: no issue while the completion queue is full
    a_r9_no_overflow: assert property (@(posedge clk) disable iff (rst)
        full |-> !push);

    // R10: a pulse is always caused by a completion on the previous edge
    a_r10_irq_cause: assert property (@(posedge clk) disable iff (rst)
        notify_irq |-> $past(done_valid));

    // R11: a completion with nothing outstanding changes nothing
    a_r11_ignore_spurious: assert property (@(posedge clk) disable iff (rst)
        (done_valid && count == '0 && !push) |=> (count == '0 && !notify_irq));

endmodule

// File: rtl/desc_ring_consumer.sv
module desc_ring_consumer
    import dring_pkg::*;
#(
    parameter int RING_DEPTH = 8,
    parameter int MAX_OUTST  = 4,
    localparam int SLOT_W = $clog2(RING_DEPTH)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  logic [SLOT_W-1:0]   wr_slot,
    input  logic [ENTRY_W-1:0]  wr_data,
    input  logic                allow_sel,
    input  logic [SEL_W-1:0]    default_fifo,
    output logic                cmd_valid,
    input  logic                cmd_ready,
    output logic [BYTES_W-1:0]  cmd_bytes,
    output logic                cmd_last,
    output logic                cmd_discard,
    output logic                cmd_notify,
    output logic [SEL_W-1:0]    cmd_fifo,
    output logic [HANDLE_W-1:0] cmd_handle,
    input  logic                done_valid,
    output logic                notify_irq
);

    ring_entry_t       wr_entry;
    ring_entry_t       rd_entry;
    logic [SLOT_W-1:0] rd_addr;
    xfer_cmd_t         cmd;
    logic              fire;
    logic              fire_irq;
    logic              full;

    assign wr_entry = ring_entry_t'(wr_data);

    dring_mem #(.DEPTH(RING_DEPTH)) u_mem (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_slot  (wr_slot),
        .wr_entry (wr_entry),
        .rd_addr  (rd_addr),
        .rd_entry (rd_entry)
    );

    dring_fetch #(.DEPTH(RING_DEPTH)) u_fetch (
        .clk          (clk),
        .rst          (rst),
        .rd_addr      (rd_addr),
        .rd_entry     (rd_entry),
        .allow_sel    (allow_sel),
        .default_fifo (default_fifo),
        .stall_full   (full),
        .cmd_valid    (cmd_valid),
        .cmd_ready    (cmd_ready),
        .cmd          (cmd),
        .fire         (fire),
        .fire_irq     (fire_irq)
    );

    dring_track #(.MAX_OUTST(MAX_OUTST)) u_track (
        .clk        (clk),
        .rst        (rst),
        .push       (fire),
        .push_irq   (fire_irq),
        .done_valid (done_valid),
        .full       (full),
        .notify_irq (notify_irq)
    );

    assign cmd_bytes   = cmd.bytes;
    assign cmd_last    = cmd.last;
    assign cmd_discard = cmd.discard;
    assign cmd_notify  = cmd.notify;
    assign cmd_fifo    = cmd.fifo;
    assign cmd_handle  = cmd.handle;

    // R5: discard commands never carry a byte count
    a_r5_discard_zero: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_discard) |-> (cmd_bytes == '0));

endmodule

// File: tb/desc_ring_consumer_bench.sv
module desc_ring_consumer_bench;

    localparam int D     = 8;
    localparam int OUTST = 4;
    localparam int N     = 60;
    localparam int SW    = $clog2(D);

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [SW-1:0] wr_slot = '0;
    logic [31:0] wr_data = '0;
    logic        allow_sel = 1'b0;
    logic [5:0]  default_fifo = 6'd13;
    logic        cmd_valid;
    logic        cmd_ready = 1'b0;
    logic [13:0] cmd_bytes;
    logic        cmd_last, cmd_discard, cmd_notify;
    logic [5:0]  cmd_fifo;
    logic [7:0]  cmd_handle;
    logic        done_valid = 1'b0;
    logic        notify_irq;

    int checks = 0;
    int fails  = 0;
    int consumed = 0;
    int completed = 0;
    int outst = 0;
    logic exp_irq = 1'b0;
    logic hold_ready = 1'b0;
    logic quiet_done = 1'b0;
    logic force_done = 1'b0;
    logic [31:0] exp_word [64];
    logic        irq_q    [64];

    always #4 clk = ~clk;

    desc_ring_consumer #(.RING_DEPTH(D), .MAX_OUTST(OUTST)) u_desc_ring_consumer (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_slot(wr_slot), .wr_data(wr_data),
        .allow_sel(allow_sel), .default_fifo(default_fifo), .cmd_valid(cmd_valid),
        .cmd_ready(cmd_ready), .cmd_bytes(cmd_bytes), .cmd_last(cmd_last),
        .cmd_discard(cmd_discard), .cmd_notify(cmd_notify), .cmd_fifo(cmd_fifo),
        .cmd_handle(cmd_handle), .done_valid(done_valid), .notify_irq(notify_irq)
    );

    // R1 layout: gen[31] sel[30:25] discard[24] notify[23] last[22] bytes[21:8] handle[7:0]
    function automatic logic [31:0] mk(input logic g, input logic [5:0] sel, input logic dis,
                                       input logic ntf, input logic lst,
                                       input logic [13:0] b, input logic [7:0] h);
        return {g, sel, dis, ntf, lst, b, h};
    endfunction

    function automatic logic lap_gen(input int n);
        return ((n / D) % 2) == 0;
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic put(input int slot, input logic [31:0] w);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_slot = SW'(slot);
        wr_data = w;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic wait_for(input int target);
        int t = 0;
        while (consumed < target && t < 4000) begin
            @(negedge clk);
            t++;
        end
    endtask

    task automatic gen_entry(input int n, input logic [31:0] w_in);
        exp_word[n] = w_in;
        while (n - consumed >= D) @(negedge clk);
        put(n % D, w_in);
    endtask

    function automatic logic [31:0] rnd_entry(input int n);
        logic [13:0] b;
        b = (($urandom % 4) == 0) ? 14'd0 : 14'($urandom);
        return mk(lap_gen(n), 6'($urandom), ($urandom % 5) == 0, 1'($urandom),
                  1'($urandom), b, 8'($urandom));
    endfunction

    // Monitor and downstream model: sample away from the rising edge
    always @(negedge clk) begin
        logic [31:0] w;
        logic [13:0] eb;
        if (!rst) begin
            checks++;
            if (notify_irq !== exp_irq) begin
                fails++;
                $display("FAIL R10 notify_irq actual=%0d expected=%0d", notify_irq, exp_irq);
            end
        end
        exp_irq = 1'b0;
        cmd_ready  = hold_ready ? 1'b0 : (($urandom % 4) != 0);
        done_valid = !rst && (force_done || (!quiet_done && (($urandom % 3) == 0)));
        #1;
        if (!rst) begin
            if (cmd_valid && outst >= OUTST) begin
                fails++; checks++;
                $display("FAIL R9 cmd_valid with outstanding actual=%0d expected<%0d", outst, OUTST);
            end
            // R11: a completion with nothing outstanding retires nothing
            if (done_valid && outst > 0) begin
                exp_irq = irq_q[completed];
                completed++;
                outst--;
            end
            if (cmd_valid && cmd_ready) begin
                w  = exp_word[consumed];
                eb = w[24] ? 14'd0 : w[21:8];
                check("R5 bytes", cmd_bytes, eb);
                check("R5 last", cmd_last, w[22]);
                check("R5 discard", cmd_discard, w[24]);
                check("R5 notify", cmd_notify, w[23]);
                check("R6 handle", cmd_handle, (w[21:8] == 0) ? 0 : w[7:0]);
                check("R7 fifo", cmd_fifo, allow_sel ? w[30:25] : default_fifo);
                irq_q[consumed] = w[22] & w[23];
                consumed++;
                outst++;
            end
        end
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R2 cmd_valid after reset", cmd_valid, 0);
        check("R2 notify_irq after reset", notify_irq, 0);
        repeat (20) @(negedge clk);
        check("R2 cleared ring not consumed", consumed, 0);

        // R11: spurious completion with nothing outstanding
        quiet_done = 1'b1; force_done = 1'b1;
        @(negedge clk);
        force_done = 1'b0;
        repeat (3) @(negedge clk);
        quiet_done = 1'b0;

        // lap 0, directed corner entries
        gen_entry(0, mk(1'b1, 6'd5, 1'b0, 1'b1, 1'b1, 14'd64, 8'hA1));
        gen_entry(1, mk(1'b1, 6'd7, 1'b0, 1'b0, 1'b0, 14'd0, 8'h5C));   // R6 zero length
        gen_entry(2, mk(1'b1, 6'd9, 1'b1, 1'b1, 1'b1, 14'd300, 8'h33)); // R5 discard
        gen_entry(3, mk(1'b1, 6'd1, 1'b0, 1'b1, 1'b0, 14'd16383, 8'hFF));
        for (int n = 4; n < D; n++) gen_entry(n, rnd_entry(n));
        wait_for(D);
        check("R4 lap 0 consumed", consumed, D);

        // R3: slot 0 still holds lap 0 generation, must not be taken again
        repeat (25) @(negedge clk);
        check("R3 stale entry ignored", consumed, D);
        check("R3 no command offered", cmd_valid, 0);

        // R8: stall on ready
        hold_ready = 1'b1;
        gen_entry(D, mk(lap_gen(D), 6'd2, 1'b0, 1'b1, 1'b1, 14'd8, 8'h11));
        repeat (12) @(negedge clk);
        check("R8 valid held", cmd_valid, 1);
        check("R8 no advance", consumed, D);
        check("R8 bytes held", cmd_bytes, 8);
        hold_ready = 1'b0;

        for (int n = D + 1; n < 20; n++) gen_entry(n, rnd_entry(n));
        wait_for(20);

        // R3: rewrite polled slot with wrong generation, then fix it
        put(20 % D, mk(~lap_gen(20), 6'd3, 1'b0, 1'b0, 1'b1, 14'd40, 8'h77));
        repeat (15) @(negedge clk);
        check("R3 wrong generation ignored", consumed, 20);
        gen_entry(20, mk(lap_gen(20), 6'd4, 1'b0, 1'b1, 1'b1, 14'd41, 8'h78));

        for (int n = 21; n < 30; n++) gen_entry(n, rnd_entry(n));
        wait_for(30);
        allow_sel = 1'b1;   // R7 selection path
        for (int n = 30; n < N; n++) gen_entry(n, rnd_entry(n));
        wait_for(N);
        check("R4 all laps consumed in order", consumed, N);

        quiet_done = 1'b0;
        repeat (100) @(negedge clk);
        check("R10 all completions retired", completed, N);
        repeat (20) @(negedge clk);
        check("R3 no extra command after last lap", consumed, N);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule